// File: doc/BRIEF.md
# Overlay Window Shadow Register Bank

The bank stores the configuration of several overlay windows twice. Software writes a front copy through a plain register port at any time. The display pipeline reads an active copy, and the bank refreshes that copy from the front copy on the frame sync pulse. Each window has a guard bit. While the guard is set, frame syncs leave that window's active copy alone, so a half-written setup never reaches the screen. The window is refreshed at the first sync after software clears the guard.

Each window holds these registers: two corner registers (upper-left and lower-right, both inclusive), an area register, a 4-bit-per-colour blend value, a colour-key control word, a colour-key match word and a control register. Windows differ in what they have. Window 0 has no blend value and no colour-key words. Only the low-numbered windows have an area register. The control register holds the shadowed window enable, plus two bits that act at once: the fetch-channel enable and the guard.

The register port has no back-pressure. A write is taken in the cycle it is presented. Reads are combinational: `rd_data` returns the front copy and `dbg_data` returns the active copy.

Top module: `win_shadow_bank`

## Requirements
- R1: `wr_addr[5:3]` selects the window and `wr_addr[2:0]` selects the register: 0 upper-left corner (x in [11:0], y in [27:16]), 1 lower-right corner (same layout), 2 area (bits [23:0]), 3 blend (blue [3:0], green [7:4], red [11:8]), 4 key control (32 bits), 5 key match (32 bits), 6 control (bit0 window enable, bit1 fetch enable, bit2 guard), 7 unused. Bits outside these fields read as zero. `rd_data` returns the front copy of `rd_addr` in the same cycle.
- R2: A write lands in the front copy at the clock edge that samples it. The active copy and the `act_*` outputs do not change until a sync.
- R3: At an edge where `vsync` is high, every unguarded window copies registers 0 to 5 and its window enable from front to active. The copy uses the values held before that edge, so a write in the same cycle changes only the front copy.
- R4: A guarded window keeps its active copy across any number of syncs. The guard is judged by the value held before the edge, so clearing it in a sync cycle defers the copy to the next sync.
- R5: The guard and the fetch enable are not shadowed. Each takes effect at the edge of its write and drives `dma_en` directly.
- R6: Window 0 has no blend, key control or key match register. Writes to them are dropped, and they read as zero on both ports and on the outputs.
- R7: Windows 3 and 4 have no area register. It behaves as in R6.
- R8: Writes to window numbers 5 to 7, or to register 7 of any window, change no state.
- R9: `dbg_data` returns the active copy with the layout of R1. For register 6 it returns the active window enable together with the live guard and fetch enable.
- R10: Reset clears both copies, the guards and the fetch enables.
- R11: Disable sequence: guard the window while clearing its enable, then clear both guard and fetch enable. `dma_en` drops at that write's edge, and `act_win_en` drops at the next sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address {window, register} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Front-copy read address |
| rd_data | output | 32 | Front-copy read data |
| dbg_addr | input | 6 | Active-copy read address |
| dbg_data | output | 32 | Active-copy read data |
| vsync | input | 1 | One-cycle frame sync pulse |
| act_tl_x | output | 60 | Active upper-left x, 12 bits per window |
| act_tl_y | output | 60 | Active upper-left y |
| act_br_x | output | 60 | Active lower-right x |
| act_br_y | output | 60 | Active lower-right y |
| act_size | output | 120 | Active area, 24 bits per window |
| act_alpha | output | 60 | Active blend, 12 bits per window |
| act_keyctl | output | 160 | Active key control, 32 bits per window |
| act_keyval | output | 160 | Active key match, 32 bits per window |
| act_win_en | output | 5 | Active window enable per window |
| dma_en | output | 5 | Live fetch-channel enable per window |

## Verification
The assertions check four things on every cycle:
- a guarded window's active outputs never move, and nothing moves without a sync;
- an unguarded sync copies the front corner into the active copy;
- an active enable rises only after a sync, and a fetch enable falls only after a control write to that window;
- window 0's missing registers stay zero.

Some behaviour only the bench scenarios can show. These are the same-cycle collisions: a write during a sync, and a guard cleared during a sync. They also cover the disable sequence, aliasing from out-of-range window numbers, the debug view of live bits mixed with shadowed ones, and a reset in mid-run.

// File: rtl/win_shadow_pkg.sv
package win_shadow_pkg;
  localparam int REG_W     = 32;
  localparam int REG_AW    = 3;
  localparam int NUM_SHREG = 6;
  localparam int REGS_PER  = 8;
  localparam int Y_LSB     = 16;
  localparam int ALPHA_W   = 12;

  localparam int REG_TL    = 0;
  localparam int REG_BR    = 1;
  localparam int REG_SIZE  = 2;
  localparam int REG_ALPHA = 3;
  localparam int REG_KCTL  = 4;
  localparam int REG_KVAL  = 5;
  localparam int REG_CTL   = 6;

  localparam int CTL_WEN  = 0;
  localparam int CTL_DMA  = 1;
  localparam int CTL_PROT = 2;

  // Bits a register keeps; zero for a register the window does not have.
  function automatic logic [REG_W-1:0] field_mask(input int idx, input bit has_opt,
                                                  input bit has_size, input int coord_w);
    logic [REG_W-1:0] one;
    logic [REG_W-1:0] cm;
    one = 1;
    cm  = (one << coord_w) - one;
    case (idx)
      REG_TL, REG_BR: return cm | (cm << Y_LSB);
      REG_SIZE:       return has_size ? ((one << (2 * coord_w)) - one) : '0;
      REG_ALPHA:      return has_opt ? ((one << ALPHA_W) - one) : '0;
      REG_KCTL,
      REG_KVAL:       return has_opt ? '1 : '0;
      default:        return '0;
    endcase
  endfunction
endpackage

// File: rtl/shadow_win_slot.sv
module shadow_win_slot import win_shadow_pkg::*; #(
  parameter int COORD_W  = 12,
  parameter bit HAS_OPT  = 1'b1,
  parameter bit HAS_SIZE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [REG_AW-1:0] wr_reg,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              vsync,
  output logic [REG_W-1:0]  front_q  [REGS_PER],
  output logic [REG_W-1:0]  active_q [REGS_PER],
  output logic              act_wen,
  output logic              dma_en,
  output logic              prot
);
  logic [REG_W-1:0] front_r [NUM_SHREG];
  logic [REG_W-1:0] act_r   [NUM_SHREG];
  logic             wen_f;
  logic             copy_now;

  assign copy_now = vsync && !prot;

  for (genvar i = 0; i < NUM_SHREG; i++) begin : g_reg
    localparam logic [REG_W-1:0] MASK = field_mask(i, HAS_OPT, HAS_SIZE, COORD_W);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        front_r[i] <= '0;
        act_r[i]   <= '0;
      end else begin
        if (copy_now) act_r[i] <= front_r[i];
        if (wr_sel && wr_reg == REG_AW'(i)) front_r[i] <= wr_data & MASK;
      end
    end
    assign front_q[i]  = front_r[i];
    assign active_q[i] = act_r[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_f   <= 1'b0;
      act_wen <= 1'b0;
      dma_en  <= 1'b0;
      prot    <= 1'b0;
    end else begin
      if (copy_now) act_wen <= wen_f;
      if (wr_sel && wr_reg == REG_AW'(REG_CTL)) begin
        wen_f  <= wr_data[CTL_WEN];
        dma_en <= wr_data[CTL_DMA];
        prot   <= wr_data[CTL_PROT];
      end
    end
  end

  assign front_q[REG_CTL]    = {{(REG_W-3){1'b0}}, prot, dma_en, wen_f};
  assign active_q[REG_CTL]   = {{(REG_W-3){1'b0}}, prot, dma_en, act_wen};
  assign front_q[REGS_PER-1]  = '0;
  assign active_q[REGS_PER-1] = '0;
endmodule

// File: rtl/win_shadow_rdmux.sv
module win_shadow_rdmux import win_shadow_pkg::*; #(
  parameter int NUM_WIN = 5,
  parameter int WIN_AW  = 3
) (
  input  logic [REG_W-1:0]         words [NUM_WIN][REGS_PER],
  input  logic [WIN_AW+REG_AW-1:0] addr,
  output logic [REG_W-1:0]         data
);
  always_comb begin
    data = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (addr[WIN_AW+REG_AW-1:REG_AW] == WIN_AW'(w)) data = words[w][addr[REG_AW-1:0]];
    end
  end
endmodule

// File: rtl/win_shadow_bank.sv
module win_shadow_bank import win_shadow_pkg::*; #(
  parameter int NUM_WIN    = 5,
  parameter int COORD_W    = 12,
  parameter int SIZED_WINS = 3,
  localparam int WIN_AW    = $clog2(NUM_WIN),
  localparam int ADDR_W    = WIN_AW + REG_AW,
  localparam int SIZE_W    = 2 * COORD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [REG_W-1:0]           wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [REG_W-1:0]           rd_data,
  input  logic [ADDR_W-1:0]          dbg_addr,
  output logic [REG_W-1:0]           dbg_data,
  input  logic                       vsync,
  output logic [NUM_WIN*COORD_W-1:0] act_tl_x,
  output logic [NUM_WIN*COORD_W-1:0] act_tl_y,
  output logic [NUM_WIN*COORD_W-1:0] act_br_x,
  output logic [NUM_WIN*COORD_W-1:0] act_br_y,
  output logic [NUM_WIN*SIZE_W-1:0]  act_size,
  output logic [NUM_WIN*ALPHA_W-1:0] act_alpha,
  output logic [NUM_WIN*REG_W-1:0]   act_keyctl,
  output logic [NUM_WIN*REG_W-1:0]   act_keyval,
  output logic [NUM_WIN-1:0]         act_win_en,
  output logic [NUM_WIN-1:0]         dma_en
);
  logic [REG_W-1:0]         front_words [NUM_WIN][REGS_PER];
  logic [REG_W-1:0]         act_words   [NUM_WIN][REGS_PER];
  logic [NUM_WIN-1:0]       wr_sel;
  logic [NUM_WIN-1:0]       prot_vec;
  logic [NUM_WIN*COORD_W-1:0] front_tlx_vec;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam bit HAS_OPT = (w != 0);
    localparam bit HAS_SZ  = (w < SIZED_WINS);

    assign wr_sel[w] = wr_en && (wr_addr[ADDR_W-1:REG_AW] == WIN_AW'(w));

    shadow_win_slot #(.COORD_W(COORD_W), .HAS_OPT(HAS_OPT), .HAS_SIZE(HAS_SZ)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (wr_sel[w]),
      .wr_reg   (wr_addr[REG_AW-1:0]),
      .wr_data  (wr_data),
      .vsync    (vsync),
      .front_q  (front_words[w]),
      .active_q (act_words[w]),
      .act_wen  (act_win_en[w]),
      .dma_en   (dma_en[w]),
      .prot     (prot_vec[w])
    );

    assign act_tl_x[w*COORD_W +: COORD_W]  = act_words[w][REG_TL][COORD_W-1:0];
    assign act_tl_y[w*COORD_W +: COORD_W]  = act_words[w][REG_TL][Y_LSB +: COORD_W];
    assign act_br_x[w*COORD_W +: COORD_W]  = act_words[w][REG_BR][COORD_W-1:0];
    assign act_br_y[w*COORD_W +: COORD_W]  = act_words[w][REG_BR][Y_LSB +: COORD_W];
    assign act_size[w*SIZE_W +: SIZE_W]    = act_words[w][REG_SIZE][SIZE_W-1:0];
    assign act_alpha[w*ALPHA_W +: ALPHA_W] = act_words[w][REG_ALPHA][ALPHA_W-1:0];
    assign act_keyctl[w*REG_W +: REG_W]    = act_words[w][REG_KCTL];
    assign act_keyval[w*REG_W +: REG_W]    = act_words[w][REG_KVAL];
    assign front_tlx_vec[w*COORD_W +: COORD_W] = front_words[w][REG_TL][COORD_W-1:0];
  end

  win_shadow_rdmux #(.NUM_WIN(NUM_WIN), .WIN_AW(WIN_AW)) u_front_rd (
    .words (front_words),
    .addr  (rd_addr),
    .data  (rd_data)
  );

  win_shadow_rdmux #(.NUM_WIN(NUM_WIN), .WIN_AW(WIN_AW)) u_act_rd (
    .words (act_words),
    .addr  (dbg_addr),
    .data  (dbg_data)
  );
endmodule

// File: rtl/win_shadow_bank_chk.sv
module win_shadow_bank_chk import win_shadow_pkg::*; #(
  parameter int NUM_WIN = 5,
  parameter int COORD_W = 12,
  parameter int ADDR_W  = 6
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       vsync,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [NUM_WIN-1:0]         prot_vec,
  input logic [NUM_WIN*COORD_W-1:0] front_tlx_vec,
  input logic [NUM_WIN*COORD_W-1:0] act_tl_x,
  input logic [NUM_WIN*ALPHA_W-1:0] act_alpha,
  input logic [NUM_WIN*REG_W-1:0]   act_keyval,
  input logic [NUM_WIN-1:0]         act_win_en,
  input logic [NUM_WIN-1:0]         dma_en
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_chk
    // R4
    guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!vsync || prot_vec[w]) |=> ($stable(act_tl_x[w*COORD_W +: COORD_W]) && $stable(act_win_en[w])));

    // R3
    sync_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !prot_vec[w]) |=> act_tl_x[w*COORD_W +: COORD_W] == $past(front_tlx_vec[w*COORD_W +: COORD_W]));

    // R2
    enable_on_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_win_en[w]) |-> $past(vsync));

    // R11
    fetch_off_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dma_en[w]) |-> $past(wr_en && wr_addr == ADDR_W'(w * REGS_PER + REG_CTL)));
  end

  // R6
  win0_no_opt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_alpha[ALPHA_W-1:0] == '0 && act_keyval[REG_W-1:0] == '0);
endmodule

bind win_shadow_bank win_shadow_bank_chk #(.NUM_WIN(NUM_WIN), .COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .vsync         (vsync),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .prot_vec      (prot_vec),
  .front_tlx_vec (front_tlx_vec),
  .act_tl_x      (act_tl_x),
  .act_alpha     (act_alpha),
  .act_keyval    (act_keyval),
  .act_win_en    (act_win_en),
  .dma_en        (dma_en)
);

// File: tb/win_shadow_bank_test.sv
`timescale 1ns/1ps
module win_shadow_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0] rd_addr = '0;
  logic [5:0] dbg_addr = '0;
  logic vsync = 1'b0;
  logic [31:0] rd_data, dbg_data;
  logic [59:0] act_tl_x, act_tl_y, act_br_x, act_br_y, act_alpha;
  logic [119:0] act_size;
  logic [159:0] act_keyctl, act_keyval;
  logic [4:0] act_win_en, dma_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  win_shadow_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .dbg_addr(dbg_addr), .dbg_data(dbg_data),
    .vsync(vsync), .act_tl_x(act_tl_x), .act_tl_y(act_tl_y), .act_br_x(act_br_x),
    .act_br_y(act_br_y), .act_size(act_size), .act_alpha(act_alpha),
    .act_keyctl(act_keyctl), .act_keyval(act_keyval), .act_win_en(act_win_en),
    .dma_en(dma_en)
  );

  // Behavioural reference model
  logic [31:0] mf [5][6];
  logic [31:0] ma [5][6];
  bit mprot [5];
  bit mdma [5];
  bit mwf [5];
  bit mwa [5];

  function automatic logic [31:0] keep_mask(int w, int r);
    case (r)
      0, 1: return 32'h0FFF_0FFF;
      2: return (w < 3) ? 32'h00FF_FFFF : 32'h0;
      3: return (w != 0) ? 32'h0000_0FFF : 32'h0;
      4, 5: return (w != 0) ? 32'hFFFF_FFFF : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] model_read(bit active, logic [5:0] a);
    int w = int'(a[5:3]);
    int r = int'(a[2:0]);
    if (w >= 5) return 32'h0;
    if (r < 6) return active ? ma[w][r] : mf[w][r];
    if (r == 6) return {29'h0, mprot[w], mdma[w], active ? mwa[w] : mwf[w]};
    return 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 5; w++) begin
        for (int r = 0; r < 6; r++) begin mf[w][r] = '0; ma[w][r] = '0; end
        mprot[w] = 0; mdma[w] = 0; mwf[w] = 0; mwa[w] = 0;
      end
    end else begin
      if (vsync)
        for (int w = 0; w < 5; w++)
          if (!mprot[w]) begin
            for (int r = 0; r < 6; r++) ma[w][r] = mf[w][r];
            mwa[w] = mwf[w];
          end
      if (wr_en && wr_addr[5:3] < 3'd5) begin
        if (wr_addr[2:0] < 3'd6)
          mf[wr_addr[5:3]][wr_addr[2:0]] = wr_data & keep_mask(int'(wr_addr[5:3]), int'(wr_addr[2:0]));
        else if (wr_addr[2:0] == 3'd6) begin
          mwf[wr_addr[5:3]]   = wr_data[0];
          mdma[wr_addr[5:3]]  = wr_data[1];
          mprot[wr_addr[5:3]] = wr_data[2];
        end
      end
    end
    #1;
    chk("R1 front read", rd_data, model_read(1'b0, rd_addr));
    chk("R9 debug read", dbg_data, model_read(1'b1, dbg_addr));
    for (int w = 0; w < 5; w++) begin
      chk("R3 active tl_x", 32'(act_tl_x[w*12 +: 12]), 32'(ma[w][0][11:0]));
      chk("R3 active tl_y", 32'(act_tl_y[w*12 +: 12]), 32'(ma[w][0][27:16]));
      chk("R3 active br_x", 32'(act_br_x[w*12 +: 12]), 32'(ma[w][1][11:0]));
      chk("R3 active br_y", 32'(act_br_y[w*12 +: 12]), 32'(ma[w][1][27:16]));
      chk("R7 active size", 32'(act_size[w*24 +: 24]), ma[w][2]);
      chk("R6 active alpha", 32'(act_alpha[w*12 +: 12]), ma[w][3]);
      chk("R6 active keyctl", act_keyctl[w*32 +: 32], ma[w][4]);
      chk("R6 active keyval", act_keyval[w*32 +: 32], ma[w][5]);
      chk("R4 active enable", 32'(act_win_en[w]), 32'(mwa[w]));
      chk("R5 fetch enable", 32'(dma_en[w]), 32'(mdma[w]));
    end
  end

  task automatic op(bit we, logic [5:0] a, logic [31:0] d, bit vs);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; vsync = vs;
  endtask

  task automatic rdchk(string tag, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    wr_en = 0; vsync = 0; rd_addr = a;
    #1 chk(tag, rd_data, exp);
  endtask

  task automatic dbgchk(string tag, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    wr_en = 0; vsync = 0; dbg_addr = a;
    #1 chk(tag, dbg_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rdchk("R10 reset control", {3'd1, 3'd6}, 32'h0);
    dbgchk("R10 reset active", {3'd1, 3'd0}, 32'h0);

    op(1, {3'd1, 3'd0}, 32'hFFFF_FFFF, 0);
    rdchk("R1 corner mask", {3'd1, 3'd0}, 32'h0FFF_0FFF);
    dbgchk("R2 active before sync", {3'd1, 3'd0}, 32'h0);
    op(0, 6'd0, 32'h0, 1);
    dbgchk("R3 copy at sync", {3'd1, 3'd0}, 32'h0FFF_0FFF);

    op(1, {3'd2, 3'd6}, 32'h4, 0);
    op(1, {3'd2, 3'd1}, 32'h0023_0045, 0);
    op(0, 6'd0, 32'h0, 1);
    op(0, 6'd0, 32'h0, 1);
    dbgchk("R4 guarded hold", {3'd2, 3'd1}, 32'h0);
    rdchk("R5 guard live", {3'd2, 3'd6}, 32'h4);
    op(1, {3'd2, 3'd6}, 32'h1, 1);
    dbgchk("R4 guard cleared in sync cycle", {3'd2, 3'd1}, 32'h0);
    op(0, 6'd0, 32'h0, 1);
    dbgchk("R4 copy after guard clear", {3'd2, 3'd1}, 32'h0023_0045);
    dbgchk("R9 debug control", {3'd2, 3'd6}, 32'h1);

    op(1, {3'd1, 3'd0}, 32'h0005_0006, 1);
    dbgchk("R3 same-cycle write", {3'd1, 3'd0}, 32'h0FFF_0FFF);
    rdchk("R3 same-cycle front", {3'd1, 3'd0}, 32'h0005_0006);
    op(0, 6'd0, 32'h0, 1);
    dbgchk("R3 later copy", {3'd1, 3'd0}, 32'h0005_0006);

    op(1, {3'd0, 3'd3}, 32'hFFFF_FFFF, 0);
    op(1, {3'd0, 3'd4}, 32'h1234_5678, 0);
    op(1, {3'd0, 3'd5}, 32'h9ABC_DEF0, 1);
    rdchk("R6 win0 alpha", {3'd0, 3'd3}, 32'h0);
    rdchk("R6 win0 key ctl", {3'd0, 3'd4}, 32'h0);
    dbgchk("R6 win0 key val", {3'd0, 3'd5}, 32'h0);
    op(1, {3'd1, 3'd3}, 32'hFFFF_FABC, 0);
    rdchk("R1 alpha mask", {3'd1, 3'd3}, 32'h0000_0ABC);

    op(1, {3'd3, 3'd2}, 32'h0000_1234, 0);
    op(1, {3'd2, 3'd2}, 32'h0102_0304, 0);
    rdchk("R7 win3 no size", {3'd3, 3'd2}, 32'h0);
    rdchk("R1 size mask", {3'd2, 3'd2}, 32'h0002_0304);

    op(1, {3'd5, 3'd0}, 32'h0777_0777, 0);
    op(1, {3'd1, 3'd7}, 32'hFFFF_FFFF, 0);
    rdchk("R8 window 5 ignored", {3'd5, 3'd0}, 32'h0);
    rdchk("R8 no alias", {3'd1, 3'd0}, 32'h0005_0006);
    rdchk("R8 register 7", {3'd1, 3'd7}, 32'h0);

    op(1, {3'd4, 3'd6}, 32'h2, 0);
    @(negedge clk); wr_en = 0; #1;
    chk("R5 fetch enable immediate", 32'(dma_en[4]), 32'h1);
    chk("R2 enable not yet active", 32'(act_win_en[4]), 32'h0);

    op(1, {3'd2, 3'd6}, 32'h3, 1);
    op(0, 6'd0, 32'h0, 1);
    op(1, {3'd2, 3'd6}, 32'h6, 0);
    op(0, 6'd0, 32'h0, 1);
    dbgchk("R9 live guard with active enable", {3'd2, 3'd6}, 32'h7);
    rdchk("R11 front control", {3'd2, 3'd6}, 32'h6);
    op(1, {3'd2, 3'd6}, 32'h0, 0);
    @(negedge clk); wr_en = 0; #1;
    chk("R11 fetch off at write", 32'(dma_en[2]), 32'h0);
    chk("R11 enable held", 32'(act_win_en[2]), 32'h1);
    op(0, 6'd0, 32'h0, 1);
    @(negedge clk); vsync = 0; #1;
    chk("R11 enable off at sync", 32'(act_win_en[2]), 32'h0);

    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    chk("R10 reset front", rd_data, 32'h0);
    chk("R10 reset fetch", 32'(dma_en), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    rdchk("R10 cleared corner", {3'd1, 3'd0}, 32'h0);
    dbgchk("R10 cleared active", {3'd2, 3'd1}, 32'h0);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule